// File: doc/BRIEF.md
# I2C Master Interrupt and Status Unit

This block holds the interrupt side of the register interface of an I2C master controller. Software reaches it through 16-bit register reads and writes at fixed byte offsets. Inside the block are a six-flag status word, an interrupt enable mask and a test register. The transfer engine raises status flags through one-cycle event inputs. The block drives a single level interrupt that is high while any enabled flag is set.

A revision parameter picks one of two register behaviours. The legacy revision (0x11) treats status as read-only. It acknowledges interrupts through a vector register: reading that register returns the position of the lowest pending enabled flag and clears that flag. The newer revision (0x34) drops the vector register. Instead it clears status flags when software writes 1 to them, has a soft-reset command register, and has a test bit that forces every flag high. A write to a read-only or unused offset raises a one-cycle access-error pulse.

Writes take effect at the clock edge on which `reg_wr` is sampled. `reg_rdata` is combinational: it is valid in the cycle `reg_rd` is high and shows the state before that edge. `acc_err` and `soft_rst` are high during the cycle after the write that caused them.

Top module: `i2cm_irq_stat`

## Requirements
- R1: `irq` is high exactly when the status flags ANDed with the enable mask are non-zero. After reset, status, mask and test are zero and `irq` is low.
- R2: A write to offset 0x04 stores the enable mask. The legacy revision keeps only bits [4:0] and the newer revision keeps bits [5:0]. A read of 0x04 returns the stored mask.
- R3: Each bit of `evt_set` sets the status flag at the same position. In the same cycle a set wins over any clear, except the soft reset.
- R4: A read of offset 0x08 returns the flags in bits [5:0] and `bus_busy` in bit 12. In the newer revision, a write to 0x08 clears each flag whose bit in wdata[5:0] is 1. In the legacy revision, that write changes nothing and is an access error.
- R5: In the legacy revision, a read of 0x0C returns the 1-based index of the lowest set bit of flags AND mask, or 0 if there is none, and clears that flag. In the newer revision, a read of 0x0C returns 0 and clears nothing. In both revisions a write to 0x0C is an access error.
- R6: A read of offset 0x10 returns `mod_en` in bit 0 and 0 in all other bits. A write to 0x10 is an access error.
- R7: In the newer revision, a write to offset 0x20 with wdata bit 1 set clears status, mask and test, and pulses `soft_rst` in the next cycle. A read of 0x20 returns 0. In the legacy revision, a write to 0x20 is an access error with no effect.
- R8: A write to offset 0x3C stores wdata AND 0xF80F, which reads back at 0x3C. In the newer revision, a write with wdata bit 11 set also sets all six flags.
- R9: A read of offset 0x00 returns the revision value (0x11 legacy, 0x34 newer). A write to 0x00 is an access error.
- R10: `acc_err` is high for exactly the cycle after any write to a read-only or unused offset. Reads never raise it, and reads of unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational, zero when not reading |
| evt_set | input | 6 | Flag-set pulses from the transfer engine |
| bus_busy | input | 1 | Bus busy indication shown in the status read |
| mod_en | input | 1 | Module enable bit of the controller's control register |
| irq | output | 1 | Level interrupt |
| acc_err | output | 1 | Pulse on a bad write |
| soft_rst | output | 1 | Pulse after a soft-reset command |

## Verification
The bench drives both revisions side by side and goes after the points where the revisions differ. These points are the mask width, the 0x08 write, the 0x0C read, the 0x20 command and the force bit. A design that mixed up the revisions would show the wrong mask read-back, clear read-only flags, or raise the wrong error. Successive vector reads expose an encoder that picks the highest flag, ignores the mask, or forgets to clear, because each of these returns a wrong index sequence. A flag-clear write in the same cycle as an event on that flag catches a design that gives the clear priority and loses the event. Soft reset followed by read-back catches a design that leaves mask or test state behind.

// File: rtl/i2cm_irq_pkg.sv
package i2cm_irq_pkg;
  localparam int FLAG_W    = 6;
  localparam int DATA_W    = 16;
  localparam int IDX_W     = $clog2(FLAG_W + 1);
  localparam int NEWER_MIN = 'h34;

  localparam int OFS_REV  = 'h00;
  localparam int OFS_MASK = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_VEC  = 'h0C;
  localparam int OFS_ENA  = 'h10;
  localparam int OFS_SYSC = 'h20;
  localparam int OFS_TEST = 'h3C;

  localparam int BUSY_BIT  = 12;
  localparam int SRST_BIT  = 1;
  localparam int FORCE_BIT = 11;
  localparam logic [DATA_W-1:0] TEST_KEEP = 16'hF80F;

  // Flags the enable mask may hold for a given revision.
  function automatic logic [FLAG_W-1:0] mask_keep(input bit newer);
    mask_keep = newer ? {FLAG_W{1'b1}} : {1'b0, {(FLAG_W-1){1'b1}}};
  endfunction

  // 1-based index of the lowest set bit, 0 when none is set.
  function automatic logic [IDX_W-1:0] lowest_one(input logic [FLAG_W-1:0] v);
    lowest_one = '0;
    for (int i = FLAG_W - 1; i >= 0; i--) begin
      if (v[i]) lowest_one = IDX_W'(i + 1);
    end
  endfunction
endpackage

// File: rtl/i2cm_acc_decode.sv
module i2cm_acc_decode
  import i2cm_irq_pkg::*;
#(
  parameter bit NEWER  = 1'b1,
  parameter int ADDR_W = 8
) (
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              srst_bit,
  input  logic              force_bit,
  output logic              wr_mask,
  output logic              wr_stat,
  output logic              wr_test,
  output logic              test_force,
  output logic              soft_clr,
  output logic              rd_vec,
  output logic              bad_wr
);
  always_comb begin
    wr_mask    = 1'b0;
    wr_stat    = 1'b0;
    wr_test    = 1'b0;
    test_force = 1'b0;
    soft_clr   = 1'b0;
    bad_wr     = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        ADDR_W'(OFS_MASK): wr_mask = 1'b1;
        ADDR_W'(OFS_STAT): begin
          if (NEWER) wr_stat = 1'b1;
          else       bad_wr  = 1'b1;
        end
        ADDR_W'(OFS_SYSC): begin
          if (NEWER) soft_clr = srst_bit;
          else       bad_wr   = 1'b1;
        end
        ADDR_W'(OFS_TEST): begin
          wr_test    = 1'b1;
          test_force = NEWER && force_bit;
        end
        default: bad_wr = 1'b1;
      endcase
    end
  end

  assign rd_vec = !NEWER && reg_rd && (reg_addr == ADDR_W'(OFS_VEC));
endmodule

// File: rtl/i2cm_vec_enc.sv
module i2cm_vec_enc
  import i2cm_irq_pkg::*;
(
  input  logic [FLAG_W-1:0] pend,
  output logic [IDX_W-1:0]  vec_idx,
  output logic [FLAG_W-1:0] vec_bit
);
  assign vec_idx = lowest_one(pend);
  // Isolate the lowest set bit: the flag a vector read acknowledges.
  assign vec_bit = pend & ~(pend - FLAG_W'(1));
endmodule

// File: rtl/i2cm_flag_bank.sv
module i2cm_flag_bank
  import i2cm_irq_pkg::*;
#(
  parameter bit NEWER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic              wr_test,
  input  logic              test_force,
  input  logic [FLAG_W-1:0] vec_clr,
  input  logic [FLAG_W-1:0] evt_set,
  input  logic [DATA_W-1:0] wdata,
  output logic [FLAG_W-1:0] stat_q,
  output logic [FLAG_W-1:0] mask_q,
  output logic [DATA_W-1:0] test_q
);
  localparam logic [FLAG_W-1:0] KEEP = mask_keep(NEWER);

  logic [FLAG_W-1:0] stat_d, mask_d;
  logic [DATA_W-1:0] test_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_stat)    stat_d = stat_d & ~wdata[FLAG_W-1:0];
    stat_d = stat_d & ~vec_clr;
    if (test_force) stat_d = {FLAG_W{1'b1}};
    stat_d = stat_d | evt_set;

    mask_d = wr_mask ? (wdata[FLAG_W-1:0] & KEEP) : mask_q;
    test_d = wr_test ? (wdata & TEST_KEEP) : test_q;

    if (soft_clr) begin
      stat_d = '0;
      mask_d = '0;
      test_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      test_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      test_q <= test_d;
    end
  end
endmodule

// File: rtl/i2cm_irq_stat.sv
module i2cm_irq_stat
  import i2cm_irq_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h34,
  parameter int         ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [FLAG_W-1:0] evt_set,
  input  logic              bus_busy,
  input  logic              mod_en,
  output logic              irq,
  output logic              acc_err,
  output logic              soft_rst
);
  localparam bit NEWER = (int'(REV_ID) >= NEWER_MIN);

  logic              wr_mask, wr_stat, wr_test, test_force, soft_clr, rd_vec, bad_wr;
  logic [FLAG_W-1:0] stat_q, mask_q, pend, vec_bit;
  logic [DATA_W-1:0] test_q;
  logic [IDX_W-1:0]  vec_idx;
  logic              err_q, srst_q;

  i2cm_acc_decode #(.NEWER(NEWER), .ADDR_W(ADDR_W)) u_dec (
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .srst_bit   (reg_wdata[SRST_BIT]),
    .force_bit  (reg_wdata[FORCE_BIT]),
    .wr_mask    (wr_mask),
    .wr_stat    (wr_stat),
    .wr_test    (wr_test),
    .test_force (test_force),
    .soft_clr   (soft_clr),
    .rd_vec     (rd_vec),
    .bad_wr     (bad_wr)
  );

  assign pend = stat_q & mask_q;

  i2cm_vec_enc u_vec (
    .pend    (pend),
    .vec_idx (vec_idx),
    .vec_bit (vec_bit)
  );

  i2cm_flag_bank #(.NEWER(NEWER)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .wr_mask    (wr_mask),
    .wr_stat    (wr_stat),
    .wr_test    (wr_test),
    .test_force (test_force),
    .vec_clr    (rd_vec ? vec_bit : '0),
    .evt_set    (evt_set),
    .wdata      (reg_wdata),
    .stat_q     (stat_q),
    .mask_q     (mask_q),
    .test_q     (test_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(OFS_REV):  reg_rdata = DATA_W'(REV_ID);
        ADDR_W'(OFS_MASK): reg_rdata = DATA_W'(mask_q);
        ADDR_W'(OFS_STAT): begin
          reg_rdata[FLAG_W-1:0] = stat_q;
          reg_rdata[BUSY_BIT]   = bus_busy;
        end
        ADDR_W'(OFS_VEC):  reg_rdata = NEWER ? '0 : DATA_W'(vec_idx);
        ADDR_W'(OFS_ENA):  reg_rdata[0] = mod_en;
        ADDR_W'(OFS_TEST): reg_rdata = test_q;
        default:           reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      err_q  <= bad_wr;
      srst_q <= soft_clr;
    end
  end

  assign irq      = |pend;
  assign acc_err  = err_q;
  assign soft_rst = srst_q;
endmodule

// File: rtl/i2cm_irq_chk.sv
module i2cm_irq_chk
  import i2cm_irq_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h34,
  parameter int         ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [FLAG_W-1:0] evt_set,
  input logic [FLAG_W-1:0] stat_q,
  input logic [FLAG_W-1:0] mask_q,
  input logic              irq,
  input logic              acc_err,
  input logic              soft_rst
);
  localparam bit NEWER = (int'(REV_ID) >= NEWER_MIN);
  localparam logic [FLAG_W-1:0] KEEP = mask_keep(NEWER);

  p_mask_zero_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_MASK) && reg_wdata[FLAG_W-1:0] == '0) |=> !irq);

  p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_MASK)) |=>
      (mask_q == ($past(reg_wdata[FLAG_W-1:0]) & KEEP)));

  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_addr == ADDR_W'(OFS_SYSC))) |=> ((stat_q & $past(evt_set)) == $past(evt_set)));

  p_w1c_newer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (NEWER && reg_wr && reg_addr == ADDR_W'(OFS_STAT)) |=>
      ((stat_q & $past(reg_wdata[FLAG_W-1:0]) & ~$past(evt_set)) == '0));

  p_stat_ro_legacy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEWER && reg_wr && reg_addr == ADDR_W'(OFS_STAT) && evt_set == '0 && !reg_rd) |=>
      $stable(stat_q));

  p_sysc_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFS_SYSC)) |-> (reg_rdata == '0));

  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (NEWER && reg_wr && reg_addr == ADDR_W'(OFS_SYSC) && reg_wdata[SRST_BIT]) |=>
      (soft_rst && stat_q == '0 && mask_q == '0));

  p_force_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (NEWER && reg_wr && reg_addr == ADDR_W'(OFS_TEST) && reg_wdata[FORCE_BIT]) |=>
      (stat_q == {FLAG_W{1'b1}}));

  p_rev_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFS_REV)) |-> (reg_rdata == DATA_W'(REV_ID)));

  p_ro_write_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == ADDR_W'(OFS_REV) || reg_addr == ADDR_W'(OFS_ENA))) |=> acc_err);

  p_no_err_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> !acc_err);
endmodule

bind i2cm_irq_stat i2cm_irq_chk #(.REV_ID(REV_ID), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .evt_set   (evt_set),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .irq       (irq),
  .acc_err   (acc_err),
  .soft_rst  (soft_rst)
);

// File: tb/tb_i2cm_irq_stat.sv
module tb_i2cm_irq_stat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [5:0]  evt_set = '0;
  logic        bus_busy = 1'b0, mod_en = 1'b0;
  logic [15:0] rdata_n, rdata_l;
  logic        irq_n, irq_l, err_n, err_l, srst_n, srst_l;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_irq_stat #(.REV_ID(8'h34)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .evt_set(evt_set), .bus_busy(bus_busy),
    .mod_en(mod_en), .irq(irq_n), .acc_err(err_n), .soft_rst(srst_n));

  i2cm_irq_stat #(.REV_ID(8'h11)) dut_leg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_l), .evt_set(evt_set), .bus_busy(bus_busy),
    .mod_en(mod_en), .irq(irq_l), .acc_err(err_l), .soft_rst(srst_l));

  int n_chk = 0, n_err = 0;
  // Reference state: index 0 legacy, index 1 newer.
  int m_stat[2], m_mask[2], m_test[2], m_err[2], m_srst[2];

  function automatic int first_flag(int v);
    for (int i = 0; i < 6; i++) if ((v >> i) & 1) return i + 1;
    return 0;
  endfunction

  function automatic int exp_read(int m, int a, int busy, int en);
    case (a)
      'h00: return (m == 1) ? 'h34 : 'h11;
      'h04: return m_mask[m];
      'h08: return m_stat[m] | (busy << 12);
      'h0C: return (m == 1) ? 0 : first_flag(m_stat[m] & m_mask[m]);
      'h10: return en;
      'h3C: return m_test[m];
      default: return 0;
    endcase
  endfunction

  function automatic string read_tag(int a);
    case (a)
      'h00: return "R9";
      'h04: return "R2";
      'h08: return "R3/R4";
      'h0C: return "R5";
      'h10: return "R6";
      'h20: return "R7";
      'h3C: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(int m, bit wr, bit rd, int a, int wd, int ev);
    bit newer = (m == 1);
    int v;
    m_err[m]  = 0;
    m_srst[m] = 0;
    if (wr) begin
      case (a)
        'h04: m_mask[m] = wd & (newer ? 'h3F : 'h1F);
        'h08: if (newer) m_stat[m] = m_stat[m] & ~(wd & 'h3F); else m_err[m] = 1;
        'h20: begin
          if (!newer) m_err[m] = 1;
          else if ((wd >> 1) & 1) m_srst[m] = 1;
        end
        'h3C: begin
          m_test[m] = wd & 'hF80F;
          if (newer && ((wd >> 11) & 1)) m_stat[m] = 'h3F;
        end
        default: m_err[m] = 1;
      endcase
    end
    if (rd && a == 'h0C && !newer) begin
      v = first_flag(m_stat[m] & m_mask[m]);
      if (v != 0) m_stat[m] = m_stat[m] & ~(1 << (v - 1));
    end
    m_stat[m] = m_stat[m] | ev;
    if (m_srst[m] == 1) begin
      m_stat[m] = 0;
      m_mask[m] = 0;
      m_test[m] = 0;
    end
  endtask

  // One clock: drive at the falling edge, compare, then advance the model at the rising edge.
  task automatic cyc(bit wr, bit rd, int a, int wd, int ev, bit busy = 0, bit en = 0);
    reg_wr = wr; reg_rd = rd; reg_addr = 8'(a); reg_wdata = 16'(wd);
    evt_set = 6'(ev); bus_busy = busy; mod_en = en;
    #1;
    for (int m = 0; m < 2; m++) begin
      string sfx = (m == 1) ? " newer" : " legacy";
      int rdv  = (m == 1) ? int'(rdata_n) : int'(rdata_l);
      int irqv = (m == 1) ? int'(irq_n) : int'(irq_l);
      int errv = (m == 1) ? int'(err_n) : int'(err_l);
      int srv  = (m == 1) ? int'(srst_n) : int'(srst_l);
      check("R1", {"irq", sfx}, irqv, ((m_stat[m] & m_mask[m]) != 0) ? 1 : 0);
      check("R10", {"acc_err", sfx}, errv, m_err[m]);
      check("R7", {"soft_rst", sfx}, srv, m_srst[m]);
      if (rd) check(read_tag(a), $sformatf("rdata@%0h%s", a, sfx), rdv, exp_read(m, a, busy, en));
    end
    @(posedge clk);
    for (int m = 0; m < 2; m++) model_step(m, wr, rd, a, wd, ev);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_stat[m] = 0; m_mask[m] = 0; m_test[m] = 0; m_err[m] = 0; m_srst[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and identification reads (R9, R6)
    cyc(0, 1, 'h08, 0, 0);
    cyc(0, 1, 'h04, 0, 0);
    cyc(0, 1, 'h00, 0, 0);
    cyc(0, 1, 'h10, 0, 0, 0, 1);
    cyc(0, 1, 'h10, 0, 0, 0, 0);
    // R3 events, R2 mask width, R4 busy bit
    cyc(0, 0, 0, 0, 'b101100);
    cyc(1, 0, 'h04, 'hFFFF, 0);
    cyc(0, 1, 'h04, 0, 0);
    cyc(0, 1, 'h08, 0, 0, 1);
    // R5 vector reads: legacy 3, 4, 0; newer always 0
    cyc(0, 1, 'h0C, 0, 0);
    cyc(0, 1, 'h0C, 0, 0);
    cyc(0, 1, 'h0C, 0, 0);
    cyc(0, 1, 'h08, 0, 0);
    cyc(1, 0, 'h0C, 1, 0);
    // R4 write-1-clear, and R3 event beats a clear in the same cycle
    cyc(1, 0, 'h08, 'h24, 0);
    cyc(0, 1, 'h08, 0, 0);
    cyc(1, 0, 'h08, 'h3F, 'h01);
    cyc(0, 1, 'h08, 0, 0);
    // R8 test register and force bit
    cyc(1, 0, 'h3C, 'hFFFF, 0);
    cyc(0, 1, 'h3C, 0, 0);
    cyc(0, 1, 'h08, 0, 0);
    cyc(1, 0, 'h3C, 'h0005, 0);
    cyc(0, 1, 'h3C, 0, 0);
    // R10 bad writes and unused reads
    cyc(1, 0, 'h00, 'hFFFF, 0);
    cyc(1, 0, 'h10, 'hFFFF, 0);
    cyc(1, 0, 'h30, 'h1234, 0);
    cyc(0, 1, 'h30, 0, 0);
    cyc(0, 1, 'h20, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // R7 soft reset: bit 1 clear does nothing, bit 1 set clears (newer)
    cyc(1, 0, 'h3C, 'h000F, 0);
    cyc(1, 0, 'h20, 'h0001, 0);
    cyc(0, 1, 'h04, 0, 0);
    cyc(1, 0, 'h20, 'h0002, 0);
    cyc(0, 1, 'h04, 0, 0);
    cyc(0, 1, 'h08, 0, 0);
    cyc(0, 1, 'h3C, 0, 0);
    // R1 irq falls when the mask is cleared
    cyc(0, 0, 0, 0, 'h3F);
    cyc(1, 0, 'h04, 'h0002, 0);
    cyc(1, 0, 'h04, 'h0000, 0);
    cyc(0, 1, 'h08, 0, 0);
    cyc(0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule